// File: doc/BRIEF.md
# Strobe-Triggered Sampler Front End

This block is the device side of an 8-bit audio sampler that sits on a parallel port. The host reads the data pins and then pulses a strobe line. The block treats each rising strobe edge as the command to take one new sample. It starts the analog-to-digital converter, waits for the converter to finish, and then latches the result onto the data pins. The byte is then ready for the host's next read. The host's read rate is therefore the sample rate. The block always runs one sample behind, so the byte read before any strobe has arrived is not a real sample.

The strobe is asynchronous to the block clock, so it passes through a synchronizer before its rising edge is detected. A four-state machine runs each conversion. Its states are IDLE, START, WAIT_BUSY and LATCH, and its transitions are:
- IDLE to START on an edge.
- START to WAIT_BUSY unconditionally.
- WAIT_BUSY to LATCH when busy drops.
- LATCH to START on an edge, and LATCH to IDLE otherwise.

An edge that arrives in START or WAIT_BUSY is an overrun. It is counted and otherwise dropped. Two counters report the number of latched samples and the number of overruns.

The converter must follow this handshake:
- It raises `adc_busy` on the clock edge that samples `adc_start` high.
- It holds `adc_busy` high until `adc_data` carries the result.
- It keeps `adc_data` steady until the next start.

Top module: `strobe_sampler`

## Requirements
- R1: After reset, `port_data` is 0x00, `data_valid` is 0, both counters are 0 and `adc_start` is 0.
- R2: Each rising edge of `strobe_in` seen in IDLE or LATCH produces exactly one `adc_start` pulse, one clock wide, issued on the third rising clock edge after the strobe goes high.
- R3: `port_data` changes only when a sample is latched. It then takes the `adc_data` value present after `adc_busy` fell, and it holds that value until the next latch.
- R4: `data_valid` stays 0 until the first sample is latched. From then on it stays 1.
- R5: `sample_count` rises by exactly one for each latched sample and wraps modulo 2^CW.
- R6: A strobe rising edge that arrives in START or WAIT_BUSY raises `overrun_count` by one. It issues no `adc_start` and leaves `port_data` unchanged.
- R7: A strobe held high for any length of time starts only one conversion, because only the rising edge is acted on.
- R8: The number of `adc_start` pulses equals the number of latched samples once each conversion has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_in | input | 1 | Host strobe, asynchronous |
| adc_start | output | 1 | One-cycle conversion start |
| adc_busy | input | 1 | Converter busy |
| adc_data | input | DW | Converter result |
| port_data | output | DW | Byte driven to the port data pins |
| data_valid | output | 1 | Pins carry a real sample |
| sample_count | output | CW | Latched samples, wrapping |
| overrun_count | output | CW | Strobe edges dropped during a conversion |

## Verification
The bench sends isolated strobe pulses carrying distinct bytes, including 0x00 and 0xFF. These confirm that each edge latches exactly its own conversion result and that the valid flag becomes and stays set.

A second strobe rising inside a running conversion separates an overrun from a restart. It checks that the pins keep the first result and that only the overrun count moves.

A strobe held high for a long time separates edge detection from level detection.

The count of start pulses against latched samples exposes any duplicated or lost conversion.

// File: rtl/smp_pkg.sv
package smp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_START     = 2'd1,
        ST_WAIT_BUSY = 2'd2,
        ST_LATCH     = 2'd3
    } smp_state_e;
endpackage

// File: rtl/smp_edge_sync.sv
module smp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // Stages 0..STAGES-1 synchronize; stage STAGES holds the previous value.
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/smp_counter.sv
module smp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (inc) q <= q + 1'b1;
    end
endmodule

// File: rtl/smp_conv_fsm.sv
module smp_conv_fsm
    import smp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic busy,
    output logic start,
    output logic latch_en,
    output logic overrun_hit
);
    smp_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (go) state_nx = ST_START;
            ST_START:     state_nx = ST_WAIT_BUSY;
            ST_WAIT_BUSY: if (!busy) state_nx = ST_LATCH;
            ST_LATCH:     state_nx = go ? ST_START : ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        start       = 1'b0;
        latch_en    = 1'b0;
        overrun_hit = 1'b0;
        unique case (state)
            ST_IDLE:      ;
            ST_START:     begin start = 1'b1; overrun_hit = go; end
            ST_WAIT_BUSY: overrun_hit = go;
            ST_LATCH:     latch_en = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
    parameter int DW          = 8,
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_in,
    output logic          adc_start,
    input  logic          adc_busy,
    input  logic [DW-1:0] adc_data,
    output logic [DW-1:0] port_data,
    output logic          data_valid,
    output logic [CW-1:0] sample_count,
    output logic [CW-1:0] overrun_count
);
    logic strobe_rise;
    logic latch_en;
    logic overrun_hit;

    smp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(strobe_in), .rise(strobe_rise)
    );

    smp_conv_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(strobe_rise), .busy(adc_busy),
        .start(adc_start), .latch_en(latch_en), .overrun_hit(overrun_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_data  <= '0;
            data_valid <= 1'b0;
        end else if (latch_en) begin
            port_data  <= adc_data;
            data_valid <= 1'b1;
        end
    end

    smp_counter #(.W(CW)) u_smp_cnt (
        .clk(clk), .rst_n(rst_n), .inc(latch_en), .q(sample_count)
    );

    smp_counter #(.W(CW)) u_ovr_cnt (
        .clk(clk), .rst_n(rst_n), .inc(overrun_hit), .q(overrun_count)
    );
endmodule

// File: rtl/strobe_sampler_chk.sv
module strobe_sampler_chk #(
    parameter int DW = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adc_start,
    input logic          adc_busy,
    input logic [DW-1:0] port_data,
    input logic          data_valid,
    input logic [CW-1:0] sample_count,
    input logic [CW-1:0] overrun_count
);
    // R2
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R3
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sample_count) |-> $stable(port_data));

    // R4
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> data_valid);

    // R4
    valid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> (sample_count == '0));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sample_count) |-> (sample_count == CW'($past(sample_count) + 1'b1)));

    // R6
    overrun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(overrun_count) |-> (!adc_start && $stable(port_data)));

    // R3
    no_latch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_busy |=> $stable(sample_count));
endmodule

bind strobe_sampler strobe_sampler_chk #(.DW(DW), .CW(CW)) u_chk (.*);

// File: tb/test_strobe_sampler.sv
module test_strobe_sampler;
    localparam int DW   = 8;
    localparam int CW   = 16;
    localparam int CONV = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_in = 1'b0;
    logic          adc_start;
    logic          adc_busy;
    logic [DW-1:0] adc_data;
    logic [DW-1:0] port_data;
    logic          data_valid;
    logic [CW-1:0] sample_count;
    logic [CW-1:0] overrun_count;

    int total = 0;
    int bad   = 0;
    int starts = 0;
    bit done = 1'b0;
    logic [DW-1:0] model_next = '0;
    logic [DW-1:0] exp_q[$];
    int conv_cnt;

    always #5 clk = ~clk;

    strobe_sampler #(.DW(DW), .CW(CW)) i_strobe_sampler (
        .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in),
        .adc_start(adc_start), .adc_busy(adc_busy), .adc_data(adc_data),
        .port_data(port_data), .data_valid(data_valid),
        .sample_count(sample_count), .overrun_count(overrun_count)
    );

    // Converter model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_busy <= 1'b0;
            adc_data <= '0;
            conv_cnt <= 0;
        end else if (adc_start) begin
            adc_busy <= 1'b1;
            conv_cnt <= CONV;
            starts   <= starts + 1;
        end else if (adc_busy) begin
            if (conv_cnt == 1) begin
                adc_busy <= 1'b0;
                adc_data <= model_next;
            end
            conv_cnt <= conv_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop an expected byte whenever the sample count moves
    logic [CW-1:0] last_cnt = '0;
    always @(negedge clk) begin
        if (rst_n && sample_count != last_cnt) begin
            last_cnt = sample_count;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected latch", int'(port_data), 0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(port_data == e, "R3 latched byte", int'(port_data), int'(e));
                check(data_valid, "R4 valid after latch", int'(data_valid), 1);
            end
        end
    end

    // Driver: one host strobe carrying byte v
    task automatic host_strobe(input logic [DW-1:0] v, input int high_cycles);
        model_next = v;
        exp_q.push_back(v);
        @(negedge clk) strobe_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        strobe_in = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(port_data == 0, "R1 port_data", int'(port_data), 0);
        check(!data_valid, "R1 valid", int'(data_valid), 0);
        check(sample_count == 0, "R1 sample_count", int'(sample_count), 0);
        check(overrun_count == 0, "R1 overrun_count", int'(overrun_count), 0);
        check(!adc_start, "R1 adc_start", int'(adc_start), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 start latency: strobe rises at a negedge, pulse after third edge
        model_next = 8'h3C;
        exp_q.push_back(8'h3C);
        strobe_in = 1'b1;
        repeat (2) @(negedge clk);
        check(!adc_start, "R2 no early start", int'(adc_start), 0);
        check(!data_valid, "R4 valid low before latch", int'(data_valid), 0);
        @(negedge clk);
        check(adc_start, "R2 start pulse", int'(adc_start), 1);
        @(negedge clk);
        check(!adc_start, "R2 start one cycle", int'(adc_start), 0);
        strobe_in = 1'b0;
        repeat (20) @(negedge clk);

        host_strobe(8'hA5, 3);
        host_strobe(8'h00, 3);
        host_strobe(8'hFF, 3);
        host_strobe(8'h5A, 1);
        check(sample_count == 5, "R5 count after five", int'(sample_count), 5);
        check(port_data == 8'h5A, "R3 pins hold", int'(port_data), 8'h5A);

        // R6 overrun: second edge inside a running conversion
        model_next = 8'h81;
        exp_q.push_back(8'h81);
        strobe_in = 1'b1;
        repeat (3) @(negedge clk);
        strobe_in = 1'b0;
        repeat (2) @(negedge clk);
        strobe_in = 1'b1;
        repeat (3) @(negedge clk);
        strobe_in = 1'b0;
        repeat (25) @(negedge clk);
        check(overrun_count == 1, "R6 overrun counted", int'(overrun_count), 1);
        check(sample_count == 6, "R6 no extra sample", int'(sample_count), 6);
        check(port_data == 8'h81, "R6 pins keep first result", int'(port_data), 8'h81);

        // R7 long high strobe
        host_strobe(8'h77, 60);
        check(sample_count == 7, "R7 single conversion", int'(sample_count), 7);
        check(port_data == 8'h77, "R7 byte", int'(port_data), 8'h77);

        // R8
        check(starts == int'(sample_count), "R8 starts equal samples", starts, int'(sample_count));
        check(exp_q.size() == 0, "R3 all expected latched", exp_q.size(), 0);
        check(data_valid, "R4 valid stays set", int'(data_valid), 1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule